// File: doc/BRIEF.md
# Externally Clocked Link-Port Shift Engine

This block is the receiving end of an 8-bit, full-duplex serial link whose bit clock comes from the far side. The far side is the master and drives the link clock. The block passes the link clock and the serial input through two-flop synchronisers into the system clock domain. It acts on edges of the synchronised clock:

- A rising edge samples the serial input into a receive byte, most significant bit first.
- A falling edge puts the top bit of a transmit byte on the serial output.

Every eighth rising edge closes a byte. At that point the received byte is handed to the host with a one-cycle strobe, and the next transmit byte is chosen. That byte is the host's queued byte if one is waiting. Otherwise it is a programmable filler byte.

The host writes transmit bytes through a simple write port. A write made between bytes goes straight into the transmit shifter. A write made during a byte waits in a one-entry pending slot. A second write to a full slot replaces the waiting byte and raises a sticky overrun flag, which the host clears with an acknowledge.

A programmable inactivity limit, given in microseconds, protects the bit count from a lost clock edge. If the gap since the previous rising edge is longer than the limit, the partial byte is thrown away and the current bit is counted as the first bit of a new byte. A toggle on the clock-source select input also forces the bit count back to zero.

The control is a two-state machine:

- **ST_IDLE**: between bytes, bit count zero.
- **ST_SHIFT**: inside a byte.

Its transitions are:

- **first-bit**: ST_IDLE to ST_SHIFT on a rising edge.
- **next-bit**: ST_SHIFT to ST_SHIFT on a rising edge below the eighth.
- **stale-restart**: ST_SHIFT to ST_SHIFT on a rising edge after an expired gap, with the count set to one.
- **byte-done**: ST_SHIFT to ST_IDLE on the eighth rising edge.
- **source-resync**: any state to ST_IDLE on a clock-source change.

Top module: `link_slave_port`

## Requirements
- R1: On each rising edge of the synchronised link clock, the receive byte shifts left by one and takes the sampled serial-input level in bit 0, so the first bit received ends as bit 7.
- R2: On each falling edge of the synchronised link clock, `link_sdo_o` takes bit 7 of the transmit shifter and the shifter then shifts left by one. `link_sdo_o` changes at no other time.
- R3: The eighth counted rising edge returns the bit count to zero. `rx_data_o` then holds the completed byte, and `rx_valid_o` is high for exactly one system cycle, the cycle after that edge is registered.
- R4: At each byte boundary, the transmit shifter loads the pending byte if one is waiting and clears the pending slot. Otherwise it loads the filler byte. The filler resets to 0x00, and a filler write is used from the next boundary on.
- R5: A host transmit write while the bit count is zero loads the transmit shifter directly and discards any pending byte. A write while the count is nonzero goes to the pending slot.
- R6: On a rising edge, if more than `tmo_us × CYC_PER_US` system cycles have passed since the previous rising edge, the receive byte and bit count are cleared before the current bit is taken. The limit resets to 500 µs, and a new limit applies from the next rising edge.
- R7: `ovr_o` sets when a transmit write arrives mid-byte while a pending byte is still waiting. The new byte replaces the waiting one. `ovr_o` stays set until `ovr_ack_i`, and a set in the same cycle as an acknowledge wins.
- R8: Any change of `src_sel_i` returns the bit count to zero, and the next eight rising edges form a whole byte.
- R9: After reset, `link_sdo_o`, `rx_valid_o` and `ovr_o` are low, the transmit shifter holds 0x00, and the synchronisers read high, so an idle-high link clock gives no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_clk_i | input | 1 | Link clock from the far side (asynchronous) |
| link_sdi_i | input | 1 | Serial data from the far side (asynchronous) |
| link_sdo_o | output | 1 | Serial data to the far side |
| src_sel_i | input | 1 | Clock-source select; any change resyncs the bit count |
| tx_wr_i | input | 1 | Host transmit-byte write strobe |
| tx_data_i | input | 8 | Host transmit byte |
| fill_wr_i | input | 1 | Filler-byte write strobe |
| fill_data_i | input | 8 | Filler byte value |
| tmo_wr_i | input | 1 | Inactivity-limit write strobe |
| tmo_us_i | input | 16 | Inactivity limit in microseconds |
| ovr_ack_i | input | 1 | Clears the overrun flag |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is complete |
| rx_data_o | output | 8 | Last completed received byte |
| ovr_o | output | 1 | Sticky pending-slot overrun flag |

## Verification
The bound checker checks these properties on every cycle:

- The serial output moves only right after a detected falling edge.
- The receive strobe is a single cycle and always follows a rising edge.
- A clean byte boundary with no host write leaves the pending slot empty.
- A clock-source change leaves the bit count at zero.
- The overrun flag only rises on a write into a full pending slot and holds until it is acknowledged.

The bench scenarios are what show the byte values themselves. These are the most-significant-first assembly of received bits, the choice among a direct write, a queued byte and the filler at each boundary, and the replacement of a pending byte. The scenarios also separate a gap just under the inactivity limit, which must join the bits into one byte, from a gap over it, which must drop them.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } lsp_state_t;

    localparam int unsigned LSP_TMO_RESET_US = 500;
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] ff [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff[0] <= {WIDTH{RST_VAL}};
        else        ff[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[s] <= {WIDTH{RST_VAL}};
            else        ff[s] <= ff[s-1];
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/lsp_edge.sv
module lsp_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= lvl;
    end

    assign rise = lvl  & ~lvl_q;
    assign fall = ~lvl &  lvl_q;
endmodule

// File: rtl/lsp_gap_timer.sv
module lsp_gap_timer #(
    parameter int unsigned CYC_PER_US = 200,
    parameter int unsigned TMO_W      = 16,
    parameter int unsigned GAP_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_wr,
    input  logic [TMO_W-1:0] tmo_us,
    input  logic             rise,
    output logic             expired
);
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    logic [TMO_W-1:0] tmo_q;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmo_q <= TMO_W'(lsp_pkg::LSP_TMO_RESET_US);
        else if (tmo_wr) tmo_q <= tmo_us;
    end

    // cycles since the last rising edge, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= '0;
        else if (rise)           gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    assign limit   = GAP_W'(tmo_q) * GAP_W'(CYC_PER_US);
    assign expired = rise && (gap_q > limit);
endmodule

// File: rtl/lsp_shift_core.sv
module lsp_shift_core #(
    parameter int unsigned W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 sdi,
    input  logic                 expired,
    input  logic                 src_chg,
    input  logic                 tx_wr,
    input  logic [W-1:0]         tx_data,
    input  logic                 fill_wr,
    input  logic [W-1:0]         fill_data,
    input  logic                 ovr_ack,
    output logic                 sdo,
    output logic                 rx_valid,
    output logic [W-1:0]         rx_data,
    output logic                 ovr,
    output logic                 pend_v,
    output logic [$clog2(W)-1:0] bit_cnt,
    output lsp_pkg::lsp_state_t  state
);
    import lsp_pkg::*;

    localparam int unsigned CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    lsp_state_t st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [W-1:0] in_q, in_n, tx_q, tx_n, pend_q, pend_n, fill_q, fill_n, rxd_q, rxd_n;
    logic pv_q, pv_n, ovr_q, ovr_n, sdo_q, sdo_n, rxv_q, rxv_n;
    logic boundary;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            in_q   <= '0;
            tx_q   <= '0;
            pend_q <= '0;
            pv_q   <= 1'b0;
            fill_q <= '0;
            ovr_q  <= 1'b0;
            sdo_q  <= 1'b0;
            rxv_q  <= 1'b0;
            rxd_q  <= '0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            in_q   <= in_n;
            tx_q   <= tx_n;
            pend_q <= pend_n;
            pv_q   <= pv_n;
            fill_q <= fill_n;
            ovr_q  <= ovr_n;
            sdo_q  <= sdo_n;
            rxv_q  <= rxv_n;
            rxd_q  <= rxd_n;
        end
    end

    // next-state and output process
    always_comb begin
        st_n     = st_q;
        cnt_n    = cnt_q;
        in_n     = in_q;
        tx_n     = tx_q;
        pend_n   = pend_q;
        pv_n     = pv_q;
        fill_n   = fill_q;
        ovr_n    = ovr_q;
        sdo_n    = sdo_q;
        rxv_n    = 1'b0;
        rxd_n    = rxd_q;
        boundary = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (rise) begin                         // first-bit
                    in_n  = {in_q[W-2:0], sdi};
                    cnt_n = CNT_W'(1);
                    st_n  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (rise) begin
                    if (expired) begin                  // stale-restart
                        in_n  = {{(W-1){1'b0}}, sdi};
                        cnt_n = CNT_W'(1);
                    end else if (cnt_q == LAST_BIT) begin // byte-done
                        in_n     = {in_q[W-2:0], sdi};
                        cnt_n    = '0;
                        st_n     = ST_IDLE;
                        boundary = 1'b1;
                    end else begin                      // next-bit
                        in_n  = {in_q[W-2:0], sdi};
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (src_chg) begin                              // source-resync
            st_n     = ST_IDLE;
            cnt_n    = '0;
            in_n     = in_q;
            boundary = 1'b0;
        end

        if (boundary) begin
            rxv_n = 1'b1;
            rxd_n = in_n;
            tx_n  = pv_q ? pend_q : fill_q;
            pv_n  = 1'b0;
        end

        if (fall) begin
            sdo_n = tx_q[W-1];
            tx_n  = {tx_q[W-2:0], 1'b0};
        end

        if (fill_wr) fill_n = fill_data;

        if (ovr_ack) ovr_n = 1'b0;

        if (tx_wr) begin
            if (st_q == ST_IDLE) begin
                tx_n = tx_data;
                pv_n = 1'b0;
            end else begin
                pend_n = tx_data;
                pv_n   = 1'b1;
                if (pv_q && !boundary) ovr_n = 1'b1;
            end
        end
    end

    assign sdo      = sdo_q;
    assign rx_valid = rxv_q;
    assign rx_data  = rxd_q;
    assign ovr      = ovr_q;
    assign pend_v   = pv_q;
    assign bit_cnt  = cnt_q;
    assign state    = st_q;
endmodule

// File: rtl/link_slave_port.sv
module link_slave_port #(
    parameter int unsigned W          = 8,
    parameter int unsigned CYC_PER_US = 200,
    parameter int unsigned TMO_W      = 16,
    parameter int unsigned GAP_W      = 32,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_clk_i,
    input  logic             link_sdi_i,
    output logic             link_sdo_o,
    input  logic             src_sel_i,
    input  logic             tx_wr_i,
    input  logic [W-1:0]     tx_data_i,
    input  logic             fill_wr_i,
    input  logic [W-1:0]     fill_data_i,
    input  logic             tmo_wr_i,
    input  logic [TMO_W-1:0] tmo_us_i,
    input  logic             ovr_ack_i,
    output logic             rx_valid_o,
    output logic [W-1:0]     rx_data_o,
    output logic             ovr_o
);
    localparam int unsigned CNT_W = $clog2(W);

    logic [1:0] sync_q;
    logic rise, fall, expired, src_q, src_chg, pend_v;
    logic [CNT_W-1:0] bit_cnt;
    lsp_pkg::lsp_state_t state;

    lsp_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({link_sdi_i, link_clk_i}), .q(sync_q)
    );

    lsp_edge #(.RST_VAL(1'b1)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sync_q[0]), .rise(rise), .fall(fall)
    );

    lsp_gap_timer #(.CYC_PER_US(CYC_PER_US), .TMO_W(TMO_W), .GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr_i), .tmo_us(tmo_us_i),
        .rise(rise), .expired(expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_sel_i;
    end
    assign src_chg = src_sel_i ^ src_q;

    lsp_shift_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .rise(rise), .fall(fall), .sdi(sync_q[1]),
        .expired(expired), .src_chg(src_chg),
        .tx_wr(tx_wr_i), .tx_data(tx_data_i),
        .fill_wr(fill_wr_i), .fill_data(fill_data_i),
        .ovr_ack(ovr_ack_i),
        .sdo(link_sdo_o), .rx_valid(rx_valid_o), .rx_data(rx_data_o),
        .ovr(ovr_o), .pend_v(pend_v), .bit_cnt(bit_cnt), .state(state)
    );
endmodule

// File: rtl/lsp_checker.sv
module lsp_checker #(
    parameter int unsigned W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rise,
    input logic                 fall,
    input logic                 expired,
    input logic                 src_chg,
    input logic                 tx_wr,
    input logic                 ovr_ack,
    input logic                 sdo,
    input logic                 rx_valid,
    input logic                 ovr,
    input logic                 pend_v,
    input logic [$clog2(W)-1:0] bit_cnt,
    input lsp_pkg::lsp_state_t  state
);
    localparam logic [$clog2(W)-1:0] LAST = $clog2(W)'(W - 1);

    a_r2_sdo_only_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_strobe_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise));

    a_r4_pending_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state == lsp_pkg::ST_SHIFT && bit_cnt == LAST && !expired
         && !src_chg && !tx_wr) |=> !pend_v);

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_ack) |=> ovr);

    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(tx_wr) && $past(pend_v)));

    a_r8_source_resync: assert property (@(posedge clk) disable iff (!rst_n)
        src_chg |=> (bit_cnt == '0 && state == lsp_pkg::ST_IDLE));
endmodule

bind link_slave_port lsp_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .expired(expired), .src_chg(src_chg), .tx_wr(tx_wr_i),
    .ovr_ack(ovr_ack_i), .sdo(link_sdo_o), .rx_valid(rx_valid_o),
    .ovr(ovr_o), .pend_v(pend_v), .bit_cnt(bit_cnt), .state(state)
);

// File: tb/sim_link_slave_port.sv
`timescale 1ns/1ps
module sim_link_slave_port;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lclk = 1'b1, sdi = 1'b1, src_sel = 1'b0;
    logic tx_wr = 1'b0, fill_wr = 1'b0, tmo_wr = 1'b0, ovr_ack = 1'b0;
    logic [7:0] tx_data = '0, fill_data = '0;
    logic [15:0] tmo_us = '0;
    logic sdo, rx_valid, ovr;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0, rx_cnt = 0;
    logic [7:0] rx_last = '0;
    bit done = 0;

    // bench model of the transmit side
    logic [7:0] m_tx = 8'h00, m_pend = 8'h00, m_fill = 8'h00;
    logic m_pv = 1'b0, m_ovr = 1'b0;

    always #2.5 clk = ~clk;

    link_slave_port #(.CYC_PER_US(1)) u0 (
        .clk(clk), .rst_n(rst_n), .link_clk_i(lclk), .link_sdi_i(sdi),
        .link_sdo_o(sdo), .src_sel_i(src_sel), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
        .fill_wr_i(fill_wr), .fill_data_i(fill_data), .tmo_wr_i(tmo_wr),
        .tmo_us_i(tmo_us), .ovr_ack_i(ovr_ack), .rx_valid_o(rx_valid),
        .rx_data_o(rx_data), .ovr_o(ovr)
    );

    always @(negedge clk) if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
    end

    function automatic logic [7:0] pick_next(logic pv, logic [7:0] pend, logic [7:0] fill);
        return pv ? pend : fill;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic link_bit(input logic b, output logic o);
        @(negedge clk); lclk = 1'b0; sdi = b;
        repeat (HALF) @(negedge clk);
        o = sdo; lclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic host_tx(input logic [7:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_data = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_fill(input logic [7:0] v);
        @(negedge clk); fill_wr = 1'b1; fill_data = v;
        @(negedge clk); fill_wr = 1'b0;
    endtask

    task automatic host_tmo(input logic [15:0] v);
        @(negedge clk); tmo_wr = 1'b1; tmo_us = v;
        @(negedge clk); tmo_wr = 1'b0;
    endtask

    task automatic host_ack();
        @(negedge clk); ovr_ack = 1'b1;
        @(negedge clk); ovr_ack = 1'b0;
    endtask

    // nbits bits; host writes after bit index wr_at (nwr of them)
    task automatic link_bits(input logic [7:0] din, input int nbits, input int nwr,
                             input int wr_at, input logic [7:0] v1, input logic [7:0] v2,
                             output logic [7:0] dout);
        logic o;
        dout = '0;
        for (int i = 0; i < nbits; i++) begin
            link_bit(din[7-i], o);
            dout[7-i] = o;
            if (i == wr_at && nwr >= 1) host_tx(v1);
            if (i == wr_at && nwr >= 2) host_tx(v2);
        end
    endtask

    // full byte with model update and checks
    task automatic xfer(input string tag, input logic [7:0] din, input int nwr,
                        input int wr_at, input logic [7:0] v1, input logic [7:0] v2);
        logic [7:0] dout, exp_tx;
        int c0;
        exp_tx = m_tx;
        c0 = rx_cnt;
        if (nwr >= 1) begin
            if (m_pv) m_ovr = 1'b1;
            m_pend = v1; m_pv = 1'b1;
        end
        if (nwr >= 2) begin
            m_ovr = 1'b1; m_pend = v2;
        end
        link_bits(din, 8, nwr, wr_at, v1, v2, dout);
        chk({tag, " R1 rx byte msb-first"}, {8'h0, rx_last}, {8'h0, din});
        chk({tag, " R3 one strobe per byte"}, 16'(rx_cnt - c0), 16'd1);
        chk({tag, " R2/R4/R5 tx byte"}, {8'h0, dout}, {8'h0, exp_tx});
        chk({tag, " R7 overrun flag"}, {15'h0, ovr}, {15'h0, m_ovr});
        m_tx = pick_next(m_pv, m_pend, m_fill);
        m_pv = 1'b0;
    endtask

    // partial then resumed byte; expect_join selects whether bits combine
    task automatic gap_case(input string tag, input int gap, input logic expect_join,
                            input logic [7:0] a, input logic [7:0] b);
        logic [7:0] d1, d2;
        int c0;
        c0 = rx_cnt;
        link_bits(a, 3, 0, 0, 8'h0, 8'h0, d1);
        repeat (gap) @(negedge clk);
        if (expect_join) begin
            link_bits(b, 5, 0, 0, 8'h0, 8'h0, d2);
            chk({tag, " R6 short gap joins bits"}, {8'h0, rx_last}, {8'h0, a[7:5], b[7:3]});
            chk({tag, " R6 join strobe"}, 16'(rx_cnt - c0), 16'd1);
        end else begin
            link_bits(b, 8, 0, 0, 8'h0, 8'h0, d2);
            chk({tag, " R6 long gap drops partial"}, {8'h0, rx_last}, {8'h0, b});
            chk({tag, " R6 resync strobe"}, 16'(rx_cnt - c0), 16'd1);
            chk({tag, " R6 tx continues shifted"}, {8'h0, d2}, {8'h0, m_tx[4:0], 3'b000});
        end
        m_tx = pick_next(m_pv, m_pend, m_fill);
        m_pv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d1;
        int c0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 reset state
        chk("R9 sdo low", {15'h0, sdo}, 16'h0);
        chk("R9 no strobe", {15'h0, rx_valid}, 16'h0);
        chk("R9 no overrun", {15'h0, ovr}, 16'h0);
        chk("R9 no edge from idle-high", 16'(rx_cnt), 16'h0);

        // reset transmit byte is 0x00
        xfer("first", 8'hC3, 0, 0, 8'h0, 8'h0);

        // R5 direct load, R4 filler used at next boundary
        host_tx(8'hA5); m_tx = 8'hA5; m_pv = 1'b0;
        host_fill(8'h5A); m_fill = 8'h5A;
        xfer("direct", 8'h3C, 0, 0, 8'h0, 8'h0);
        xfer("filler", 8'h81, 0, 0, 8'h0, 8'h0);

        // R5 mid-byte write queues, R4 pending preferred
        xfer("queue", 8'h7E, 1, 3, 8'hE7, 8'h0);
        xfer("queued-out", 8'h01, 0, 0, 8'h0, 8'h0);

        // R7 overrun: second write replaces, flag sticky until ack
        xfer("ovr", 8'hF0, 2, 2, 8'h11, 8'h22);
        repeat (20) @(negedge clk);
        chk("R7 overrun holds", {15'h0, ovr}, 16'h1);
        host_ack(); m_ovr = 1'b0;
        chk("R7 ack clears", {15'h0, ovr}, 16'h0);
        xfer("replaced", 8'h0F, 0, 0, 8'h0, 8'h0);

        // R6 default limit 500 cycles (CYC_PER_US=1)
        gap_case("tmo-default", 600, 1'b0, 8'hFF, 8'h96);
        host_tmo(16'd100);
        gap_case("tmo-short", 60, 1'b1, 8'hA0, 8'h58);
        gap_case("tmo-long", 150, 1'b0, 8'hE0, 8'h69);

        // R8 source change drops partial byte
        c0 = rx_cnt;
        link_bits(8'hE0, 3, 0, 0, 8'h0, 8'h0, d1);
        @(negedge clk); src_sel = ~src_sel;
        repeat (3) @(negedge clk);
        link_bits(8'h4B, 8, 0, 0, 8'h0, 8'h0, d1);
        chk("R8 resync byte", {8'h0, rx_last}, 16'h004B);
        chk("R8 resync strobe", 16'(rx_cnt - c0), 16'd1);
        m_tx = pick_next(m_pv, m_pend, m_fill); m_pv = 1'b0;

        // constrained random bytes
        for (int k = 0; k < 40; k++) begin
            int r;
            logic [7:0] din, v1, v2;
            r = int'($urandom % 4);
            din = 8'($urandom); v1 = 8'($urandom); v2 = 8'($urandom);
            if (($urandom % 3) == 0) begin
                logic [7:0] f;
                f = 8'($urandom);
                host_fill(f); m_fill = f;
            end
            if (r == 0) begin
                host_tx(v1); m_tx = v1; m_pv = 1'b0;
                xfer("rnd-direct", din, 0, 0, 8'h0, 8'h0);
            end else if (r == 1) begin
                xfer("rnd-queue", din, 1, 1 + int'($urandom % 6), v1, v2);
            end else if (r == 2) begin
                xfer("rnd-ovr", din, 2, 1 + int'($urandom % 6), v1, v2);
            end else begin
                xfer("rnd-none", din, 0, 0, 8'h0, 8'h0);
            end
            if (m_ovr) begin
                host_ack(); m_ovr = 1'b0;
                chk("R7 random ack", {15'h0, ovr}, 16'h0);
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule